// File: doc/BRIEF.md
# Clocked Two-Wire Frame Receiver with XOR Validation

This block is the receiving end of a slow, noise-tolerant two-wire link made of a clock line and a data line. Both lines are brought into the system clock domain through a two-flop synchroniser and then a digital glitch filter. The filter accepts a new level only after the line has held it for a set number of system clocks, so short spikes on either wire are removed before any decoding happens.

Once filtered, each rising edge of the link clock captures one bit from the data line. Twenty-four bits make a frame: a first data byte, a second data byte, and a check byte equal to the XOR of the two data bytes. A frame whose check byte matches is presented on the outputs with a one-cycle valid strobe. A frame that fails the check is thrown away: the outputs keep their old contents, and an error strobe fires while a saturating counter records the failure. If the link clock goes quiet in the middle of a frame for longer than a timeout, the partial frame is dropped, so framing lines up again on the next transfer.

Top module: `clkdat_rx`

## Requirements
- R1: After reset, data_valid_o and chk_err_o are low, and data0_o, data1_o and err_count_o are all zero.
- R2: A bit is taken from the filtered data line on each filtered rising edge of the link clock. A high level is 1 and a low level is 0. Bits arrive most significant first, and the first byte of a frame is the first 8 bits received.
- R3: A pulse on either input line shorter than FILT_CYCLES system clocks leaves the decoded frame unchanged. Such a pulse adds no bit and flips no bit.
- R4: A frame is exactly 3 bytes: data byte 0, data byte 1, then the check byte.
- R5: When the check byte equals data byte 0 XOR data byte 1, data0_o gets byte 0 and data1_o gets byte 1, and data_valid_o is high for exactly one system clock. It is never high at the same time as chk_err_o.
- R6: When the check byte does not match, data_valid_o stays low, and chk_err_o is high for exactly one system clock.
- R7: err_count_o increases by one on each failed frame and stays at 2^ERR_W-1 once it reaches that value. It does not change at any other time.
- R8: If no filtered rising clock edge arrives for TIMEOUT_CYCLES system clocks while a frame is partly received, the partial bits are discarded. The next bit starts a new frame.
- R9: data0_o and data1_o hold the last valid frame until the next valid frame arrives. A failed frame leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_clk_i | input | 1 | Asynchronous link clock line, idles high |
| line_dat_i | input | 1 | Asynchronous link data line |
| data0_o | output | DATA_W | First data byte of the last valid frame |
| data1_o | output | DATA_W | Second data byte of the last valid frame |
| data_valid_o | output | 1 | One-cycle strobe when a valid frame is presented |
| chk_err_o | output | 1 | One-cycle strobe when a frame fails its check |
| err_count_o | output | ERR_W | Saturating count of failed frames |

## Verification
The bench builds the receiver with FILT_CYCLES = 4, TIMEOUT_CYCLES = 200 and ERR_W = 3. With these values a link bit lasts 40 system clocks, so spikes of 2 clocks fall below the filter threshold. A pause of 300 clocks in the middle of a frame triggers the framing timeout, while normal gaps between bits do not. The 3-bit counter saturates after seven failed frames, so the bench can reach the saturation point within a short run.

// File: rtl/clkdat_pkg.sv
// Shared constants and helpers for the two-wire frame receiver.
// Assumes a frame of two data words followed by one check word.
package clkdat_pkg;
    localparam int unsigned WORDS_PER_FRAME = 3;

    // Saturating increment of an up-to-32-bit counter held in the low W bits.
    function automatic logic [31:0] sat_inc(input logic [31:0] v, input int unsigned w);
        logic [31:0] top;
        top = (32'(1) << w) - 32'(1);
        return (v >= top) ? top : v + 32'(1);
    endfunction
endpackage

// File: rtl/clkdat_line_filter.sv
// Brings one asynchronous line into the clk domain through two flops, then
// accepts a level change only after it has held FILT_CYCLES clocks.
// Assumes the line idles at INIT_LEVEL during reset.
module clkdat_line_filter #(
    parameter int unsigned FILT_CYCLES = 5000,
    parameter logic        INIT_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);
    localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_CYCLES - 1);

    logic          sync_a, sync_b;
    logic          filt_q;
    logic [CW-1:0] hold_cnt;

    // Two-flop synchroniser followed by a hold-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a   <= INIT_LEVEL;
            sync_b   <= INIT_LEVEL;
            filt_q   <= INIT_LEVEL;
            hold_cnt <= '0;
        end else begin
            sync_a <= line_i;
            sync_b <= sync_a;
            if (sync_b == filt_q) begin
                hold_cnt <= '0;
            end else if (hold_cnt == LIM) begin
                filt_q   <= sync_b;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    assign level_o = filt_q;

    // R3: the filtered level only ever moves to the level the synchroniser showed.
    a_r3_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(sync_b) == filt_q));
endmodule

// File: rtl/clkdat_frame_shifter.sv
// Detects filtered rising edges of the link clock, shifts in data MSB first,
// and flags a complete frame of FRAME_BITS bits. A partial frame is dropped
// after TIMEOUT_CYCLES clocks with no edge. Assumes filtered, synchronous inputs.
module clkdat_frame_shifter #(
    parameter int unsigned FRAME_BITS     = 24,
    parameter int unsigned TIMEOUT_CYCLES = 800000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lclk_i,
    input  logic                  ldat_i,
    output logic                  frame_done_o,
    output logic [FRAME_BITS-1:0] frame_o
);
    localparam int unsigned BW = $clog2(FRAME_BITS);
    localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [TW-1:0] TO_LIM   = TW'(TIMEOUT_CYCLES - 1);

    logic                  lclk_prev;
    logic                  rise;
    logic [BW-1:0]         bit_cnt;
    logic [TW-1:0]         idle_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  done_q;

    assign rise = lclk_i & ~lclk_prev;

    // Edge history register for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lclk_prev <= 1'b1;
        else        lclk_prev <= lclk_i;
    end

    // Bit capture, frame counting and mid-frame idle timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            idle_cnt <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (rise) begin
                shreg    <= {shreg[FRAME_BITS-2:0], ldat_i};
                idle_cnt <= '0;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= '0;
                    done_q  <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (bit_cnt != '0) begin
                if (idle_cnt == TO_LIM) begin
                    bit_cnt  <= '0;
                    idle_cnt <= '0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end else begin
                idle_cnt <= '0;
            end
        end
    end

    assign frame_done_o = done_q;
    assign frame_o      = shreg;

    // R4: the bit position never leaves the frame.
    a_r4_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST_BIT);
    // R4: a finished frame needs at least one further edge before the next.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/clkdat_xor_check.sv
// Splits a finished frame into two data words and a check word, then either
// presents the data with a valid strobe or drops it with an error strobe and
// a saturating count. Assumes frame_done_i is a single-cycle strobe.
module clkdat_xor_check
    import clkdat_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ERR_W  = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  frame_done_i,
    input  logic [WORDS_PER_FRAME*DATA_W-1:0]     frame_i,
    output logic [DATA_W-1:0]                     data0_o,
    output logic [DATA_W-1:0]                     data1_o,
    output logic                                  valid_o,
    output logic                                  err_o,
    output logic [ERR_W-1:0]                      err_cnt_o
);
    logic [DATA_W-1:0] w0, w1, wchk;
    logic              match;

    assign w0    = frame_i[3*DATA_W-1 -: DATA_W];
    assign w1    = frame_i[2*DATA_W-1 -: DATA_W];
    assign wchk  = frame_i[DATA_W-1:0];
    assign match = ((w0 ^ w1) == wchk);

    // Verdict registers: publish good frames, count bad ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data0_o   <= '0;
            data1_o   <= '0;
            valid_o   <= 1'b0;
            err_o     <= 1'b0;
            err_cnt_o <= '0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            if (frame_done_i) begin
                if (match) begin
                    data0_o <= w0;
                    data1_o <= w1;
                    valid_o <= 1'b1;
                end else begin
                    err_o     <= 1'b1;
                    err_cnt_o <= ERR_W'(sat_inc(32'(err_cnt_o), ERR_W));
                end
            end
        end
    end

    // R5: valid and error strobes never coincide.
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));
    // R5: valid lasts one cycle.
    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R6: error lasts one cycle.
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);
    // R7: the counter moves only alongside an error strobe.
    a_r7_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o |-> $stable(err_cnt_o));
    // R9: data outputs change only with a valid strobe.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(data0_o) && $stable(data1_o)));
endmodule

// File: rtl/clkdat_rx.sv
// Top of the two-wire frame receiver: filters both lines, assembles
// three-word frames on link clock rising edges and validates them by XOR.
// Assumes both lines idle high while reset is asserted.
module clkdat_rx
    import clkdat_pkg::*;
#(
    parameter int unsigned DATA_W         = 8,
    parameter int unsigned FILT_CYCLES    = 5000,
    parameter int unsigned TIMEOUT_CYCLES = 800000,
    parameter int unsigned ERR_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk_i,
    input  logic              line_dat_i,
    output logic [DATA_W-1:0] data0_o,
    output logic [DATA_W-1:0] data1_o,
    output logic              data_valid_o,
    output logic              chk_err_o,
    output logic [ERR_W-1:0]  err_count_o
);
    localparam int unsigned FRAME_BITS = WORDS_PER_FRAME * DATA_W;

    logic [1:0]            raw_lines;
    logic [1:0]            clean_lines;
    logic                  frame_done;
    logic [FRAME_BITS-1:0] frame_word;

    assign raw_lines = {line_dat_i, line_clk_i};

    // One filter per line: index 0 is the clock, index 1 is the data.
    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        clkdat_line_filter #(
            .FILT_CYCLES (FILT_CYCLES),
            .INIT_LEVEL  (1'b1)
        ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_lines[gi]),
            .level_o (clean_lines[gi])
        );
    end

    clkdat_frame_shifter #(
        .FRAME_BITS     (FRAME_BITS),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .lclk_i       (clean_lines[0]),
        .ldat_i       (clean_lines[1]),
        .frame_done_o (frame_done),
        .frame_o      (frame_word)
    );

    clkdat_xor_check #(
        .DATA_W (DATA_W),
        .ERR_W  (ERR_W)
    ) u_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done_i (frame_done),
        .frame_i      (frame_word),
        .data0_o      (data0_o),
        .data1_o      (data1_o),
        .valid_o      (data_valid_o),
        .err_o        (chk_err_o),
        .err_cnt_o    (err_count_o)
    );
endmodule

// File: tb/tb_clkdat_rx.sv
// Directed bench for the two-wire frame receiver.
module tb_clkdat_rx;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned FILT   = 4;
    localparam int unsigned TMO    = 200;
    localparam int unsigned ERR_W  = 3;
    localparam int          HALF   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              line_clk = 1'b1;
    logic              line_dat = 1'b1;
    logic [DATA_W-1:0] data0, data1;
    logic              dvalid, cerr;
    logic [ERR_W-1:0]  ecount;

    int checks = 0;
    int errors = 0;
    int valid_seen = 0;
    int err_seen = 0;
    int wide_pulse = 0;
    logic prev_v = 1'b0, prev_e = 1'b0;
    bit finished = 0;

    always #5 clk = ~clk;

    clkdat_rx #(
        .DATA_W(DATA_W), .FILT_CYCLES(FILT), .TIMEOUT_CYCLES(TMO), .ERR_W(ERR_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .line_clk_i(line_clk), .line_dat_i(line_dat),
        .data0_o(data0), .data1_o(data1), .data_valid_o(dvalid),
        .chk_err_o(cerr), .err_count_o(ecount)
    );

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dvalid) valid_seen++;
            if (cerr)   err_seen++;
            if ((dvalid && prev_v) || (cerr && prev_e) || (dvalid && cerr)) wide_pulse++;
            prev_v = dvalid;
            prev_e = cerr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit glitchy);
        @(negedge clk) line_clk = 1'b0;
        line_dat = b;
        if (glitchy) begin
            repeat (5) @(negedge clk);
            line_clk = 1'b1;
            repeat (2) @(negedge clk);
            line_clk = 1'b0;
            repeat (5) @(negedge clk);
            line_dat = ~b;
            repeat (2) @(negedge clk);
            line_dat = b;
            repeat (HALF - 16) @(negedge clk);
            line_dat = ~b;
            repeat (2) @(negedge clk);
            line_dat = b;
        end else begin
            repeat (HALF) @(negedge clk);
        end
        line_clk = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w, input bit glitchy);
        for (int i = 23; i >= 0; i--) send_bit(w[i], glitchy);
        repeat (30) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(dvalid), 0);
        check("R1 err", 32'(cerr), 0);
        check("R1 data0", 32'(data0), 0);
        check("R1 data1", 32'(data1), 0);
        check("R1 count", 32'(ecount), 0);
    endtask

    task automatic t_good(input logic [7:0] a, input logic [7:0] b, input bit glitchy, input string req);
        int v0 = valid_seen;
        int e0 = err_seen;
        send_word({a, b, a ^ b}, glitchy);
        check({req, " R5 valid strobes"}, 32'(valid_seen - v0), 1);
        check({req, " R5 no err"}, 32'(err_seen - e0), 0);
        check({req, " R2 data0"}, 32'(data0), 32'(a));
        check({req, " R2 data1"}, 32'(data1), 32'(b));
    endtask

    task automatic t_bad(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                         input logic [2:0] exp_cnt);
        logic [7:0] h0 = data0;
        logic [7:0] h1 = data1;
        int v0 = valid_seen;
        int e0 = err_seen;
        send_word({a, b, c}, 1'b0);
        check("R6 no valid", 32'(valid_seen - v0), 0);
        check("R6 err strobe", 32'(err_seen - e0), 1);
        check("R9 data0 held", 32'(data0), 32'(h0));
        check("R9 data1 held", 32'(data1), 32'(h1));
        check("R7 count", 32'(ecount), 32'(exp_cnt));
    endtask

    task automatic t_timeout();
        int v0 = valid_seen;
        int e0 = err_seen;
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
        repeat (300) @(negedge clk);
        send_word({8'h5A, 8'hC3, 8'h99}, 1'b0);
        check("R8 frame after timeout valid", 32'(valid_seen - v0), 1);
        check("R8 no err after timeout", 32'(err_seen - e0), 0);
        check("R8 data0", 32'(data0), 32'h5A);
        check("R8 data1", 32'(data1), 32'hC3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        t_reset();
        t_good(8'hA5, 8'h3C, 1'b0, "R4");
        t_good(8'h80, 8'h01, 1'b0, "R2 msb");
        t_good(8'h00, 8'hFF, 1'b0, "R2 levels");
        t_bad(8'h12, 8'h34, 8'h00, 3'd1);
        t_good(8'h6B, 8'hD2, 1'b1, "R3 glitch");
        t_timeout();
        for (logic [3:0] k = 4'd2; k <= 4'd8; k++)
            t_bad(8'hF0, 8'h0F, 8'h00, (k > 4'd7) ? 3'd7 : k[2:0]);
        check("R7 saturated", 32'(ecount), 7);
        check("R5 R6 strobe width", 32'(wide_pulse), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule